// File: doc/BRIEF.md
# Pin Output-Enable and Weak-State Controller

This block sits between one logic cell output and a tristate pad. It chooses where the pad's drive enable comes from: the cell's own product-term enable, one of the global enable lines, or a fixed level. The chosen enable can be inverted separately for each pin. A configuration bit can also turn the pin into an extra ground. In that case the pad is driven low whatever the cell produces, and the cell's own logic is left untouched.

The block also models the pin's weak state. In normal user operation a bus-hold keeper holds the last level seen on the undriven pad. In every other device mode (power-up, erased, programming or internal test) the keeper gives way to a weak pull-up. In those modes the pad is never actively driven.

Only configuration and status levels cross this block's edge, and it carries no data stream. For that reason it has no valid/ready handshake and no back-pressure: every input is a plain level that takes effect at once, or at the next clock for the keeper.

Top module: `pin_oe_keeper`

## Requirements
- R1: With enable source code 3'b000, no inversion, ground off and the device mode 2'b11 (user), `pad_oe` equals `pterm_oe`.
- R2: Enable source code 3'b001 selects a constant 1. Codes 3'b010 and 3'b011 select a constant 0.
- R3: Enable source codes 3'b1xx select global enable line `goe[src[1:0]]`. When that index is at or above `NUM_GOE` (2 or 4), the selected enable is constant 0.
- R4: When `cfg_oe_inv` is 1, the selected enable is inverted before it reaches `pad_oe`. This holds for every source code.
- R5: In user mode with ground off, `pad_do` equals `cell_out` whatever the enable is.
- R6: In user mode with `cfg_gnd` set, `pad_oe` is 1 and `pad_do` is 0, whatever `cell_out`, the enable source and the inversion are.
- R7: In device modes 2'b00 (power-up), 2'b01 (erased) and 2'b10 (programming or test), `pad_oe` and `pad_do` are 0 for any configuration, including ground.
- R8: `weak_pullup` is 1 and `weak_level` is 1 in modes 2'b00, 2'b01 and 2'b10. `weak_pullup` is 0 in mode 2'b11.
- R9: In user mode, at a clock edge where `pad_oe` is 0 and `pad_in_valid` is 1, the keeper captures `pad_in`. From then on `weak_level` shows that value.
- R10: In user mode the keeper holds its value across any edge where `pad_oe` is 1 or `pad_in_valid` is 0.
- R11: Reset sets the keeper to 1. Each clock edge outside user mode reloads the keeper with 1, so on entering user mode `weak_level` starts at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the keeper register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_out | input | 1 | Logic cell output value |
| pterm_oe | input | 1 | Product-term output enable from the cell |
| goe | input | NUM_GOE | Global output-enable lines |
| dev_mode | input | 2 | Device mode: 00 power-up, 01 erased, 10 programming/test, 11 user |
| cfg_oe_src | input | 3 | Enable source code (see R1 to R3) |
| cfg_oe_inv | input | 1 | Invert the selected enable |
| cfg_gnd | input | 1 | Make the pin a driven ground |
| pad_in | input | 1 | Level sampled on the pad |
| pad_in_valid | input | 1 | Sampled pad level is a valid 0 or 1 |
| pad_do | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad drive enable |
| weak_pullup | output | 1 | 1 when the weak pull-up replaces the keeper |
| weak_level | output | 1 | Level the weak circuit holds on the pad |

## Verification
On every cycle, the assertions check four things: the ground override, the release of the pad outside user mode, the constant-1 source, and the pull-up level. They also check that the keeper captures or holds according to the drive and validity state, and that it comes back to 1 after any spell outside user mode. Only the bench's scenarios can show the full source-by-inversion matrix against the global lines, including the out-of-range indices on a two-line instance. The same holds for the data pass-through and the history of keeper values across captures, holds and mode changes.

// File: rtl/pin_oe_pkg.sv
`timescale 1ns/1ps
package pin_oe_pkg;

  typedef enum logic [1:0] {
    MODE_POWERUP = 2'b00,
    MODE_ERASED  = 2'b01,
    MODE_PROG    = 2'b10,
    MODE_USER    = 2'b11
  } dev_mode_e;

  localparam logic [2:0] OE_SRC_PTERM = 3'b000;
  localparam logic [2:0] OE_SRC_ONE   = 3'b001;
  localparam logic [2:0] OE_SRC_ZERO  = 3'b010;

  localparam int GOE_MAX = 4;
  localparam int GOE_IDX_W = $clog2(GOE_MAX);

endpackage

// File: rtl/pin_oe_sel.sv
`timescale 1ns/1ps
module pin_oe_sel
  import pin_oe_pkg::*;
#(
  parameter int NUM_GOE = 4
) (
  input  logic [2:0]         src_i,
  input  logic               inv_i,
  input  logic               pterm_i,
  input  logic [NUM_GOE-1:0] goe_i,
  output logic               oe_o
);

  logic [GOE_MAX-1:0] goe_ext;
  logic               raw_oe;

  // Pad the global lines out to the widest variant; missing lines read 0 (R3)
  generate
    for (genvar g = 0; g < GOE_MAX; g++) begin : g_goe
      if (g < NUM_GOE) begin : g_live
        assign goe_ext[g] = goe_i[g];
      end else begin : g_tied
        assign goe_ext[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (src_i[2]) begin
      raw_oe = goe_ext[src_i[GOE_IDX_W-1:0]];
    end else begin
      unique case (src_i[1:0])
        OE_SRC_PTERM[1:0]: raw_oe = pterm_i;
        OE_SRC_ONE[1:0]:   raw_oe = 1'b1;
        default:           raw_oe = 1'b0;
      endcase
    end
  end

  // Local per-pin polarity (R4)
  assign oe_o = raw_oe ^ inv_i;

endmodule

// File: rtl/pin_drive_ctl.sv
`timescale 1ns/1ps
module pin_drive_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic user_i,
  input  logic gnd_i,
  input  logic cell_i,
  input  logic oe_sel_i,
  output logic pad_do_o,
  output logic pad_oe_o
);

  always_comb begin
    if (!user_i) begin
      pad_do_o = 1'b0;
      pad_oe_o = 1'b0;
    end else if (gnd_i) begin
      pad_do_o = 1'b0;
      pad_oe_o = 1'b1;
    end else begin
      pad_do_o = cell_i;
      pad_oe_o = oe_sel_i;
    end
  end

  a_r6_ground_low: assert property (@(posedge clk) disable iff (!rst_n)
    (user_i && gnd_i) |-> (pad_oe_o && !pad_do_o));

  a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !user_i |-> (!pad_oe_o && !pad_do_o));

endmodule

// File: rtl/pin_keeper.sv
`timescale 1ns/1ps
module pin_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic user_i,
  input  logic drive_i,
  input  logic smp_i,
  input  logic smp_valid_i,
  output logic keep_o
);

  logic keep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= 1'b1;
    end else if (!user_i) begin
      keep_q <= 1'b1;
    end else if (!drive_i && smp_valid_i) begin
      keep_q <= smp_i;
    end
  end

  assign keep_o = keep_q;

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(user_i && !drive_i && smp_valid_i) |-> (keep_q == $past(smp_i)));

  a_r10_keeper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(user_i && (drive_i || !smp_valid_i)) |-> $stable(keep_q));

endmodule

// File: rtl/pin_oe_keeper.sv
`timescale 1ns/1ps
module pin_oe_keeper
  import pin_oe_pkg::*;
#(
  parameter int NUM_GOE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cell_out,
  input  logic               pterm_oe,
  input  logic [NUM_GOE-1:0] goe,
  input  logic [1:0]         dev_mode,
  input  logic [2:0]         cfg_oe_src,
  input  logic               cfg_oe_inv,
  input  logic               cfg_gnd,
  input  logic               pad_in,
  input  logic               pad_in_valid,
  output logic               pad_do,
  output logic               pad_oe,
  output logic               weak_pullup,
  output logic               weak_level
);

  logic user_mode;
  logic oe_sel;
  logic keep_val;

  assign user_mode = (dev_mode == MODE_USER);

  pin_oe_sel #(.NUM_GOE(NUM_GOE)) u_sel (
    .src_i   (cfg_oe_src),
    .inv_i   (cfg_oe_inv),
    .pterm_i (pterm_oe),
    .goe_i   (goe),
    .oe_o    (oe_sel)
  );

  pin_drive_ctl u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .user_i   (user_mode),
    .gnd_i    (cfg_gnd),
    .cell_i   (cell_out),
    .oe_sel_i (oe_sel),
    .pad_do_o (pad_do),
    .pad_oe_o (pad_oe)
  );

  pin_keeper u_keep (
    .clk         (clk),
    .rst_n       (rst_n),
    .user_i      (user_mode),
    .drive_i     (pad_oe),
    .smp_i       (pad_in),
    .smp_valid_i (pad_in_valid),
    .keep_o      (keep_val)
  );

  assign weak_pullup = !user_mode;
  assign weak_level  = user_mode ? keep_val : 1'b1;

  a_r2_const_one: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !cfg_gnd && cfg_oe_src == OE_SRC_ONE && !cfg_oe_inv) |-> pad_oe);

  a_r8_pullup_level: assert property (@(posedge clk) disable iff (!rst_n)
    weak_pullup |-> weak_level);

  a_r11_reenter_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_mode == MODE_USER) |-> weak_level);

endmodule

// File: tb/test_pin_oe_keeper.sv
`timescale 1ns/1ps
module test_pin_oe_keeper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cell_out = 1'b0;
  logic       pterm_oe = 1'b0;
  logic [3:0] goe = 4'b0;
  logic [1:0] dev_mode = 2'b11;
  logic [2:0] cfg_oe_src = 3'b000;
  logic       cfg_oe_inv = 1'b0;
  logic       cfg_gnd = 1'b0;
  logic       pad_in = 1'b0;
  logic       pad_in_valid = 1'b0;

  logic pad_do, pad_oe, weak_pullup, weak_level;
  logic n2_do, n2_oe, n2_pu, n2_wl;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";
  logic mkeep;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pin_oe_keeper #(.NUM_GOE(4)) i_pin_oe_keeper (
    .clk(clk), .rst_n(rst_n), .cell_out(cell_out), .pterm_oe(pterm_oe),
    .goe(goe), .dev_mode(dev_mode), .cfg_oe_src(cfg_oe_src),
    .cfg_oe_inv(cfg_oe_inv), .cfg_gnd(cfg_gnd), .pad_in(pad_in),
    .pad_in_valid(pad_in_valid), .pad_do(pad_do), .pad_oe(pad_oe),
    .weak_pullup(weak_pullup), .weak_level(weak_level));

  pin_oe_keeper #(.NUM_GOE(2)) i_pin_oe_keeper_n2 (
    .clk(clk), .rst_n(rst_n), .cell_out(cell_out), .pterm_oe(pterm_oe),
    .goe(goe[1:0]), .dev_mode(dev_mode), .cfg_oe_src(cfg_oe_src),
    .cfg_oe_inv(cfg_oe_inv), .cfg_gnd(cfg_gnd), .pad_in(pad_in),
    .pad_in_valid(pad_in_valid), .pad_do(n2_do), .pad_oe(n2_oe),
    .weak_pullup(n2_pu), .weak_level(n2_wl));

  // Behavioural reference of the enable after selection and inversion
  function automatic logic ref_sel(int ngoe);
    logic r;
    int idx;
    if (cfg_oe_src[2]) begin
      idx = int'(cfg_oe_src[1:0]);
      r = (idx < ngoe) ? goe[idx] : 1'b0;
    end else if (cfg_oe_src == 3'b000) r = pterm_oe;
    else if (cfg_oe_src == 3'b001) r = 1'b1;
    else r = 1'b0;
    return r ^ cfg_oe_inv;
  endfunction

  function automatic logic ref_oe(int ngoe);
    if (dev_mode != 2'b11) return 1'b0;
    if (cfg_gnd) return 1'b1;
    return ref_sel(ngoe);
  endfunction

  function automatic logic ref_do();
    if (dev_mode != 2'b11 || cfg_gnd) return 1'b0;
    return cell_out;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mkeep <= 1'b1;
    else if (dev_mode != 2'b11) mkeep <= 1'b1;
    else if (!ref_oe(4) && pad_in_valid) mkeep <= pad_in;
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("pad_oe", pad_oe, ref_oe(4));
    chk("pad_do", pad_do, ref_do());
    chk("weak_pullup", weak_pullup, dev_mode != 2'b11);
    chk("weak_level", weak_level, (dev_mode != 2'b11) ? 1'b1 : mkeep);
    chk("n2 pad_oe", n2_oe, ref_oe(2));
  endtask

  // One step per clock: drive after the falling edge, compare 1 ns later
  task automatic step();
    @(negedge clk);
    #1;
    compare_all();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state of the keeper
    repeat (3) @(negedge clk);
    #1;
    cur_req = "R11";
    compare_all();
    chk("reset weak_level", weak_level, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1..R5: every source code, both polarities, line patterns
    for (int s = 0; s < 8; s++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int j = 0; j < 32; j++) begin
          @(negedge clk);
          cfg_oe_src = 3'(s);
          cfg_oe_inv = 1'(inv);
          pterm_oe = j[0];
          goe = 4'(j >> 1);
          cell_out = j[2] ^ j[0];
          if (inv != 0) cur_req = "R4";
          else if (s == 0) cur_req = "R1";
          else if (s < 4) cur_req = "R2";
          else cur_req = "R3";
          #1;
          compare_all();
          cur_req = "R5";
          chk("data pass", pad_do, cell_out);
        end
      end
    end

    // R6: ground override against every configuration
    cur_req = "R6";
    cfg_gnd = 1'b1;
    for (int j = 0; j < 64; j++) begin
      @(negedge clk);
      cfg_oe_src = 3'(j);
      cfg_oe_inv = j[3];
      cell_out = j[4];
      pterm_oe = j[5];
      #1;
      compare_all();
      chk("gnd oe", pad_oe, 1'b1);
      chk("gnd do", pad_do, 1'b0);
    end

    // R7, R8: non-user modes release the pad and pull up
    for (int m = 0; m < 3; m++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        dev_mode = 2'(m);
        cfg_gnd = j[0];
        cfg_oe_src = 3'b001;
        cell_out = j[1];
        pad_in = j[2];
        pad_in_valid = j[3];
        cur_req = "R7";
        #1;
        compare_all();
        chk("idle oe", pad_oe, 1'b0);
        cur_req = "R8";
        chk("pullup", weak_pullup, 1'b1);
        chk("pullup level", weak_level, 1'b1);
      end
    end

    // R9: capture while undriven and valid
    @(negedge clk);
    dev_mode = 2'b11; cfg_gnd = 1'b0; cfg_oe_src = 3'b010; cfg_oe_inv = 1'b0;
    pad_in = 1'b0; pad_in_valid = 1'b1;
    cur_req = "R11";
    #1; compare_all();
    chk("enter user", weak_level, 1'b1);
    cur_req = "R9";
    step();
    chk("captured 0", weak_level, 1'b0);
    @(negedge clk); pad_in = 1'b1; #1; compare_all();
    step();
    chk("captured 1", weak_level, 1'b1);
    @(negedge clk); pad_in = 1'b0; #1; compare_all();
    step();

    // R10: hold while invalid, then while driven
    cur_req = "R10";
    @(negedge clk); pad_in = 1'b1; pad_in_valid = 1'b0; #1; compare_all();
    repeat (3) step();
    chk("hold invalid", weak_level, 1'b0);
    @(negedge clk); pad_in_valid = 1'b1; cfg_oe_src = 3'b001; #1; compare_all();
    repeat (3) step();
    chk("hold driven", weak_level, 1'b0);
    @(negedge clk); cfg_oe_src = 3'b001; cfg_gnd = 1'b1; #1; compare_all();
    repeat (2) step();
    chk("hold grounded", weak_level, 1'b0);

    // R11: leaving user mode reloads 1
    cur_req = "R11";
    @(negedge clk); cfg_gnd = 1'b0; cfg_oe_src = 3'b010; pad_in_valid = 1'b0;
    dev_mode = 2'b10; #1; compare_all();
    step();
    @(negedge clk); dev_mode = 2'b11; #1; compare_all();
    chk("reload", weak_level, 1'b1);
    repeat (4) step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule